// File: doc/BRIEF.md
# Capture/Compare Timer Channel Bank

This block places a bank of timer channels around one free-running up-counter. A select bit puts each channel in one of two modes. As an input capture, it watches a pin for a chosen edge and stores the counter value when that edge arrives. As an output compare, it watches the counter for a match with its own register and then drives its pin high, low or to the opposite level.

Software can also fire the compare action of any channel at once through a force register. A forced action leaves the channel's event flag alone. Each pin is normally general-purpose I/O, with a direction bit and a data latch. A channel in output compare with a non-zero action takes the pin over. Port data written while the timer owns the pin is kept in the latch, and that level is driven as soon as the pin is released.

All registers sit on a small synchronous register bus. Writes take effect at the clock edge where the write strobe is sampled. Reads are combinational from the address.

Top module: `cc_timer_bank`

## Requirements
- R1: The select register (address 0, bit n for channel n) resets to all zeros and reads back whatever was last written. A 0 selects input capture and a 1 selects output compare.
- R2: The counter (address 7, read only) is CW bits wide and resets to 0. It advances by one at each clock edge where cnt_tick is high, wraps from all ones to 0, and holds while cnt_tick is low.
- R3: An output-compare channel matches at a clock edge where cnt_tick is high and the counter equals the channel register (address 8+n). At that edge its compare level takes the channel's action (field bits 2n+1:2n at address 2): 01 toggles, 10 clears, 11 sets, 00 leaves it unchanged. The match also sets the channel's flag (address 4, bit n).
- R4: Writing 1 to bit n of the force register (address 1) applies channel n's action at that write's edge, but only while the channel is in output compare. A forced action never sets the flag. The force register always reads as 0.
- R5: A channel in output compare with a non-zero action owns its pin. It drives pin_oe high and pin_out with its compare level, whatever the direction and port data bits hold.
- R6: A pin that no channel owns drives pin_oe from the direction register (address 6) and pin_out from the port data latch (address 5). Port writes made while the pin is owned do not change the pin, and the latched value appears once the pin is released.
- R7: An input-capture channel uses the edge field at bits 2n+1:2n of address 3: 00 off, 01 rising, 10 falling, 11 both. The pin passes through two synchronizing flops. If the pin changes before edge k, the channel register is loaded with the counter and the flag is set at edge k+2. Edges that the field does not select change neither the register nor the flag.
- R8: Writing 1 to a flag bit clears it. A match or capture at the same edge wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, combinational |
| pin_in | input | NCH | Pin input levels |
| pin_out | output | NCH | Pin output levels |
| pin_oe | output | NCH | Pin output enables |

## Verification
The bench forces a compare on a channel that owns its pin. A design that shares the flag-set path between force and match would raise the flag here. It also writes port data while the timer owns a pin and then releases the pin; a design that gates the latch with ownership would bring back a stale level. On the capture side, it drives edges that the channel should ignore and checks the exact two-flop latency, which catches wrong edge decoding and off-by-one synchronizers. It also lands a flag-clear write on the same edge as a capture, where a design with the wrong priority would lose the event.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int A_MODE  = 0;
  localparam int A_FORCE = 1;
  localparam int A_ACT   = 2;
  localparam int A_EDGE  = 3;
  localparam int A_FLAG  = 4;
  localparam int A_PORT  = 5;
  localparam int A_DIR   = 6;
  localparam int A_CNT   = 7;
  localparam int A_CHAN  = 8;

  // Next compare level for a two-bit action code.
  function automatic logic oc_next(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   oc_next = ~cur;
      2'b10:   oc_next = 1'b0;
      2'b11:   oc_next = 1'b1;
      default: oc_next = cur;
    endcase
  endfunction

  // Whether a detected edge is selected by a two-bit edge code.
  function automatic logic edge_hit(input logic [1:0] sel, input logic rise,
                                    input logic fall);
    edge_hit = (sel[0] & rise) | (sel[1] & fall);
  endfunction

endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [1:0]    act,
  input  logic [1:0]    edg,
  input  logic [CW-1:0] cnt,
  input  logic          tick,
  input  logic          pin,
  input  logic          reg_we,
  input  logic [CW-1:0] wdata,
  input  logic          force_p,
  input  logic          flag_clr,
  output logic [CW-1:0] ccr,
  output logic          level,
  output logic          flag,
  output logic          match_ev,
  output logic          force_ev,
  output logic          cap_ev
);

  logic [2:0] sync_q;
  logic       rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pin};
  end

  assign rise     = sync_q[1] & ~sync_q[2];
  assign fall     = ~sync_q[1] & sync_q[2];

  assign match_ev = mode & tick & (cnt == ccr);
  assign force_ev = mode & force_p;
  assign cap_ev   = ~mode & edge_hit(edg, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   level <= 1'b0;
    else if (match_ev | force_ev) level <= oc_next(act, level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (match_ev | cap_ev) flag <= 1'b1;
    else if (flag_clr)          flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ccr <= '0;
    else if (cap_ev) ccr <= cnt;
    else if (reg_we) ccr <= wdata;
  end

endmodule

// File: rtl/cc_pin_mux.sv
module cc_pin_mux #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0]   mode,
  input  logic [2*NCH-1:0] act,
  input  logic [NCH-1:0]   level,
  input  logic [NCH-1:0]   port,
  input  logic [NCH-1:0]   dir,
  output logic [NCH-1:0]   owned,
  output logic [NCH-1:0]   pin_out,
  output logic [NCH-1:0]   pin_oe
);

  for (genvar n = 0; n < NCH; n++) begin : g_pin
    assign owned[n]   = mode[n] & (act[2*n+1 -: 2] != 2'b00);
    assign pin_oe[n]  = owned[n] | dir[n];
    assign pin_out[n] = owned[n] ? level[n] : port[n];
  end

endmodule

// File: rtl/cc_timer_bank.sv
module cc_timer_bank
  import cc_timer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = $clog2(A_CHAN + NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_tick,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe
);

  localparam int FW = 2 * NCH;

  logic [NCH-1:0] mode_q, port_q, dir_q;
  logic [FW-1:0]  act_q, edge_q;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  ccr [NCH];
  logic [NCH-1:0] level, flag, owned;
  logic [NCH-1:0] match_ev, force_ev, cap_ev;
  logic [NCH-1:0] force_p, flag_clr, reg_we;

  function automatic logic hit(input logic [AW-1:0] a, input int k);
    hit = (a == AW'(k));
  endfunction

  assign force_p  = (bus_we && hit(bus_addr, A_FORCE)) ? bus_wdata[NCH-1:0] : '0;
  assign flag_clr = (bus_we && hit(bus_addr, A_FLAG))  ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      act_q  <= '0;
      edge_q <= '0;
      port_q <= '0;
      dir_q  <= '0;
    end else if (bus_we) begin
      if (hit(bus_addr, A_MODE)) mode_q <= bus_wdata[NCH-1:0];
      if (hit(bus_addr, A_ACT))  act_q  <= bus_wdata[FW-1:0];
      if (hit(bus_addr, A_EDGE)) edge_q <= bus_wdata[FW-1:0];
      if (hit(bus_addr, A_PORT)) port_q <= bus_wdata[NCH-1:0];
      if (hit(bus_addr, A_DIR))  dir_q  <= bus_wdata[NCH-1:0];
    end
  end

  cc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .cnt(cnt)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign reg_we[n] = bus_we && hit(bus_addr, A_CHAN + n);
    cc_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .mode(mode_q[n]), .act(act_q[2*n+1 -: 2]), .edg(edge_q[2*n+1 -: 2]),
      .cnt(cnt), .tick(cnt_tick), .pin(pin_in[n]),
      .reg_we(reg_we[n]), .wdata(bus_wdata),
      .force_p(force_p[n]), .flag_clr(flag_clr[n]),
      .ccr(ccr[n]), .level(level[n]), .flag(flag[n]),
      .match_ev(match_ev[n]), .force_ev(force_ev[n]), .cap_ev(cap_ev[n])
    );
  end

  cc_pin_mux #(.NCH(NCH)) u_mux (
    .mode(mode_q), .act(act_q), .level(level), .port(port_q), .dir(dir_q),
    .owned(owned), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, A_MODE)) bus_rdata = CW'(mode_q);
    if (hit(bus_addr, A_ACT))  bus_rdata = CW'(act_q);
    if (hit(bus_addr, A_EDGE)) bus_rdata = CW'(edge_q);
    if (hit(bus_addr, A_FLAG)) bus_rdata = CW'(flag);
    if (hit(bus_addr, A_PORT)) bus_rdata = CW'(port_q);
    if (hit(bus_addr, A_DIR))  bus_rdata = CW'(dir_q);
    if (hit(bus_addr, A_CNT))  bus_rdata = cnt;
    for (int n = 0; n < NCH; n++)
      if (hit(bus_addr, A_CHAN + n)) bus_rdata = ccr[n];
  end

endmodule

// File: rtl/cc_timer_bank_chk.sv
module cc_timer_bank_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_tick,
  input logic [CW-1:0]  cnt,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] dir_q,
  input logic [NCH-1:0] owned,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] match_ev,
  input logic [NCH-1:0] force_ev,
  input logic [NCH-1:0] cap_ev,
  input logic [NCH-1:0] pin_oe
);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |=> cnt == $past(cnt) + CW'(1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cnt));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    p_match_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev[n] |=> flag[n]);

    p_force_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (force_ev[n] && !match_ev[n] && !flag[n]) |=> !flag[n]);

    p_owned_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      owned[n] |-> pin_oe[n]);

    p_free_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !owned[n] |-> (pin_oe[n] == dir_q[n]));

    p_cap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev[n] |=> flag[n]);

    p_cap_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev[n] |-> !mode_q[n]);
  end

endmodule

bind cc_timer_bank cc_timer_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt(cnt),
  .mode_q(mode_q), .dir_q(dir_q), .owned(owned), .flag(flag),
  .match_ev(match_ev), .force_ev(force_ev), .cap_ev(cap_ev), .pin_oe(pin_oe)
);

// File: tb/cc_timer_bank_bench.sv
`timescale 1ns/1ps
module cc_timer_bank_bench;

  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cnt_tick = 1'b0;
  logic           bus_we = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [CW-1:0]  bus_wdata = '0;
  logic [CW-1:0]  bus_rdata;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [CW-1:0] cnt_sh = '0;

  cc_timer_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_cc_timer_bank (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] d);
    bus_addr = AW'(a); #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) step();
    cnt_tick = 1'b0;
    cnt_sh = cnt_sh + CW'(n);
  endtask

  task automatic t_reset();
    logic [CW-1:0] d;
    rd(0, d); chk("R1 select reset", d, 0);
    rd(4, d); chk("R8 flags reset", d, 0);
    rd(7, d); chk("R2 counter reset", d, 0);
    chk("R6 pin_oe reset", pin_oe, 0);
    wr(0, 16'h00A5); rd(0, d); chk("R1 select readback", d, 16'h00A5);
    wr(0, 16'h0000); rd(0, d); chk("R1 select cleared", d, 0);
  endtask

  task automatic t_counter();
    logic [CW-1:0] d;
    ticks(5); rd(7, d); chk("R2 counts ticks", d, 5);
    ticks(16'hFFFF - 5); rd(7, d); chk("R2 reaches max", d, 16'hFFFF);
    ticks(1); rd(7, d); chk("R2 wraps to zero", d, 0);
    repeat (3) step(); rd(7, d); chk("R2 holds without tick", d, 0);
  endtask

  task automatic t_compare();
    logic [CW-1:0] d;
    wr(2, 16'h0003); wr(0, 16'h0001); wr(8, cnt_sh);
    chk("R5 owned pin drives", pin_oe[0], 1);
    chk("R5 level before match", pin_out[0], 0);
    ticks(1); chk("R3 set action", pin_out[0], 1);
    rd(4, d); chk("R3 match sets flag", d[0], 1);
    wr(2, 16'h0001); wr(8, cnt_sh); ticks(1); chk("R3 toggle to low", pin_out[0], 0);
    wr(8, cnt_sh); ticks(1); chk("R3 toggle to high", pin_out[0], 1);
    wr(2, 16'h0002); wr(8, cnt_sh); ticks(1); chk("R3 clear action", pin_out[0], 0);
    wr(8, cnt_sh + 16'd3); ticks(1); chk("R3 no match no change", pin_out[0], 0);
    wr(2, 16'h0000); chk("R6 released pin follows dir", pin_oe[0], 0);
    wr(4, 16'h00FF);
  endtask

  task automatic t_force();
    logic [CW-1:0] d;
    wr(0, 16'h0002); wr(2, 16'h000C);
    wr(1, 16'h0002); chk("R4 force applies action", pin_out[1], 1);
    rd(4, d); chk("R4 force leaves flag clear", d, 0);
    rd(1, d); chk("R4 force reads zero", d, 0);
    wr(1, 16'h0010); chk("R4 force ignored on capture channel", pin_oe[4], 0);
    rd(4, d); chk("R4 no flag on capture channel", d, 0);
    wr(2, 16'h0000); wr(0, 16'h0000);
  endtask

  task automatic t_port();
    wr(6, 16'h0004); wr(5, 16'h0004);
    chk("R6 free pin oe from dir", pin_oe[2], 1);
    chk("R6 free pin data from latch", pin_out[2], 1);
    wr(0, 16'h0004); wr(2, 16'h0030);
    chk("R5 owned pin ignores port data", pin_out[2], 0);
    wr(6, 16'h0000); chk("R5 owned pin ignores dir", pin_oe[2], 1);
    wr(1, 16'h0004); chk("R5 owned pin shows level", pin_out[2], 1);
    wr(5, 16'h0000); chk("R6 port write hidden while owned", pin_out[2], 1);
    wr(2, 16'h0000); wr(6, 16'h0004);
    chk("R6 latched level after release", pin_out[2], 0);
    chk("R6 released pin enabled by dir", pin_oe[2], 1);
    wr(0, 16'h0000); wr(6, 16'h0000);
  endtask

  task automatic t_capture();
    logic [CW-1:0] d, v;
    wr(3, 16'h0040); wr(11, 16'h1234); wr(4, 16'h00FF);
    v = cnt_sh;
    pin_in[3] = 1'b1; step(); step();
    rd(4, d); chk("R7 no capture before two syncs", d[3], 0);
    step();
    rd(4, d); chk("R7 rising capture flag", d[3], 1);
    rd(11, d); chk("R7 captured counter", d, v);
    ticks(3); wr(4, 16'h00FF);
    pin_in[3] = 1'b0; repeat (4) step();
    rd(4, d); chk("R7 falling ignored in rising mode", d[3], 0);
    rd(11, d); chk("R7 register kept", d, v);
    wr(3, 16'h00C0);
    pin_in[3] = 1'b1; repeat (4) step();
    rd(11, d); chk("R7 both-edges rising", d, v + 16'd3);
    ticks(2); wr(4, 16'h00FF);
    pin_in[3] = 1'b0; repeat (4) step();
    rd(4, d); chk("R7 both-edges falling flag", d[3], 1);
    rd(11, d); chk("R7 both-edges falling value", d, v + 16'd5);
    wr(3, 16'h0000); wr(4, 16'h00FF);
    pin_in[3] = 1'b1; repeat (4) step();
    rd(4, d); chk("R7 disabled edge field", d[3], 0);
    wr(3, 16'h0080);
    pin_in[3] = 1'b0; repeat (4) step();
    rd(4, d); chk("R7 falling mode capture", d[3], 1);
  endtask

  task automatic t_flags();
    logic [CW-1:0] d;
    wr(4, 16'h00FF); rd(4, d); chk("R8 write one clears", d, 0);
    wr(3, 16'h0040);
    pin_in[3] = 1'b1; step(); step();
    wr(4, 16'h0008);
    rd(4, d); chk("R8 capture beats clear", d[3], 1);
    wr(4, 16'h0008); rd(4, d); chk("R8 later clear works", d[3], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_compare();
    t_force();
    t_port();
    t_capture();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule